// File: doc/BRIEF.md
# Line Driver Gain Back-off and Thermal Protection Controller

This controller sits between the host's transmit level request and the DAC path of a line driver. It produces a 5-bit effective transmit gain on a logarithmic scale. Each step of the scale is 1 dB, and setting 31 is full scale. It guards the power amplifier against two hazards. When an over-current comparator trips, it walks the gain down one step at a time. It keeps stepping, with a programmable dwell between steps, until the sensed current drops under a second, lower comparator threshold. The reduced level is then held for the rest of the frame, and the host's requested level comes back only when the next transmission starts.

Temperature is reported by four comparator bits in thermometer form. The highest bit latches a shutdown of the amplifier. That shutdown is released only once the third bit has cleared, which gives a wide hysteresis band. The lower three bits are encoded into a 2-bit zone. A current-limit resistor select line is modelled as a data value plus an output enable. It is driven low for FSK and released to high impedance for PSK. Two sticky flags, one for over-current and one for over-temperature, record events for the host. The host clears each one by writing one.

Top module: `pa_guard_ctrl`

## Requirements
- R1: During synchronous reset, and in the first cycle after it, the outputs are as follows: eff_gain is 0, pa_en is 0, temp_zone is 0, limiting is 0, both sticky flags are 0 and rsel_oe is 0.
- R2: While not limiting and with ovc_hi low, eff_gain equals the host_gain sampled at the previous clock edge.
- R3: ovc_hi high while not limiting starts a back-off. In the next cycle limiting is 1 and eff_gain is host_gain minus one.
- R4: While limiting and ovc_lo is high, eff_gain drops by one step every dwell_cfg+1 cycles.
- R5: When ovc_lo goes low, the back-off stops and the reduced gain is held. A later ovc_hi in the same frame resumes stepping from the held value.
- R6: eff_gain never goes below 0 and never exceeds the host_gain sampled at the previous edge.
- R7: A tx_start pulse ends any back-off and loads host_gain, and it takes priority over ovc_hi in the same cycle.
- R8: With mod_fsk=1 the select line is driven (rsel_oe=1, rsel_o=0). With mod_fsk=0, rsel_oe is 0 in the next cycle.
- R9: temp_above[3] high clears pa_en in the next cycle. pa_en returns to 1 only after a cycle in which temp_above[2] is low, with temp_above[3] also low.
- R10: temp_zone reports 3 if temp_above[2] is set, else 2 if temp_above[1] is set, else 1 if temp_above[0] is set, else 0. Zones 1 to 4 are encoded as 0 to 3.
- R11: ovc_flag is set by ovc_hi and hot_flag is set by temp_above[3]. Each is cleared by a one on clr_ovc_flag or clr_hot_flag respectively, and a set in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_gain | input | 5 | Requested transmit gain, 31 = full scale |
| dwell_cfg | input | 8 | Extra cycles between back-off steps |
| tx_start | input | 1 | Pulse at the start of a transmission |
| ovc_hi | input | 1 | Current above high threshold |
| ovc_lo | input | 1 | Current above low threshold |
| mod_fsk | input | 1 | 1 = FSK, 0 = PSK |
| temp_above | input | 4 | Thermometer: bit k set = above threshold k+1 |
| clr_ovc_flag | input | 1 | Write-one-to-clear for ovc_flag |
| clr_hot_flag | input | 1 | Write-one-to-clear for hot_flag |
| eff_gain | output | 5 | Effective gain sent to the DAC path |
| pa_en | output | 1 | Power amplifier enable |
| rsel_o | output | 1 | Resistor select data value (always low) |
| rsel_oe | output | 1 | Resistor select drive enable |
| temp_zone | output | 2 | Temperature zone minus one |
| limiting | output | 1 | Back-off or hold in progress |
| ovc_flag | output | 1 | Sticky over-current flag |
| hot_flag | output | 1 | Sticky thermal shutdown flag |

## Verification
Two collisions matter most. The first is a comparator trip that lands in the same cycle as the host's write-one-to-clear of the matching sticky flag. The second is an over-current trip that lands in the same cycle as tx_start. Directed cycles raise ovc_hi together with clr_ovc_flag and check that the flag stays set. They also raise ovc_hi together with tx_start and check that the gain returns to the request with limiting low, while the flag is still recorded. The random phase makes these overlaps happen many more times, and a cycle-accurate bench model judges every output on every cycle.

// File: rtl/pa_guard_pkg.sv
package pa_guard_pkg;

  typedef enum logic [1:0] {
    BO_FOLLOW = 2'd0,
    BO_STEP   = 2'd1,
    BO_HOLD   = 2'd2
  } bo_state_e;

endpackage

// File: rtl/pa_sticky_flag.sv
module pa_sticky_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);

  // set beats clear when both arrive together
  always_ff @(posedge clk) begin
    if (rst)        flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;
    else if (clr_i) flag_o <= 1'b0;
  end

endmodule

// File: rtl/pa_gain_backoff.sv
module pa_gain_backoff
  import pa_guard_pkg::*;
#(
  parameter int GAIN_W  = 5,
  parameter int DWELL_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [GAIN_W-1:0]  host_gain,
  input  logic [DWELL_W-1:0] dwell_cfg,
  input  logic               tx_start,
  input  logic               ovc_hi,
  input  logic               ovc_lo,
  output logic [GAIN_W-1:0]  eff_gain,
  output logic               limiting
);

  bo_state_e          st_q;
  logic [DWELL_W-1:0] dwell_q;
  logic [GAIN_W-1:0]  gain_q;

  // one step down, saturating at zero
  function automatic logic [GAIN_W-1:0] step_down(input logic [GAIN_W-1:0] g);
    return (g == '0) ? '0 : g - GAIN_W'(1);
  endfunction

  // never above the current request
  function automatic logic [GAIN_W-1:0] cap(input logic [GAIN_W-1:0] g,
                                            input logic [GAIN_W-1:0] req);
    return (g > req) ? req : g;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= BO_FOLLOW;
      gain_q  <= '0;
      dwell_q <= '0;
    end else if (tx_start) begin
      st_q    <= BO_FOLLOW;
      gain_q  <= host_gain;
      dwell_q <= '0;
    end else begin
      unique case (st_q)
        BO_FOLLOW: begin
          if (ovc_hi) begin
            st_q    <= BO_STEP;
            gain_q  <= step_down(host_gain);
            dwell_q <= dwell_cfg;
          end else begin
            gain_q  <= host_gain;
          end
        end
        BO_STEP: begin
          if (!ovc_lo) begin
            st_q    <= BO_HOLD;
            gain_q  <= cap(gain_q, host_gain);
          end else if (dwell_q != '0) begin
            dwell_q <= dwell_q - DWELL_W'(1);
            gain_q  <= cap(gain_q, host_gain);
          end else begin
            gain_q  <= cap(step_down(gain_q), host_gain);
            dwell_q <= dwell_cfg;
          end
        end
        BO_HOLD: begin
          if (ovc_hi) begin
            st_q    <= BO_STEP;
            gain_q  <= cap(step_down(gain_q), host_gain);
            dwell_q <= dwell_cfg;
          end else begin
            gain_q  <= cap(gain_q, host_gain);
          end
        end
        default: begin
          st_q    <= BO_FOLLOW;
          gain_q  <= host_gain;
        end
      endcase
    end
  end

  assign eff_gain = gain_q;
  assign limiting = (st_q != BO_FOLLOW);

endmodule

// File: rtl/pa_thermal_guard.sv
module pa_thermal_guard #(
  parameter int N_TH   = 4,
  parameter int ZONE_W = $clog2(N_TH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_TH-1:0]   temp_above,
  output logic              pa_en,
  output logic [ZONE_W-1:0] zone
);

  localparam int TRIP_IDX = N_TH - 1;
  localparam int REL_IDX  = N_TH - 2;

  logic              sd_q;
  logic              sd_next;
  logic [ZONE_W-1:0] zone_next;

  // latch on the top threshold, release only below the next one down
  assign sd_next = temp_above[TRIP_IDX] | (sd_q & temp_above[REL_IDX]);

  // highest set bit below the trip threshold picks the zone
  always_comb begin
    zone_next = '0;
    for (int k = 0; k < N_TH - 1; k++) begin
      if (temp_above[k]) zone_next = ZONE_W'(k + 1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sd_q  <= 1'b0;
      pa_en <= 1'b0;
      zone  <= '0;
    end else begin
      sd_q  <= sd_next;
      pa_en <= ~sd_next;
      zone  <= zone_next;
    end
  end

endmodule

// File: rtl/pa_guard_ctrl.sv
module pa_guard_ctrl #(
  parameter int GAIN_W  = 5,
  parameter int DWELL_W = 8,
  parameter int N_TH    = 4,
  parameter int ZONE_W  = $clog2(N_TH)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [GAIN_W-1:0]  host_gain,
  input  logic [DWELL_W-1:0] dwell_cfg,
  input  logic               tx_start,
  input  logic               ovc_hi,
  input  logic               ovc_lo,
  input  logic               mod_fsk,
  input  logic [N_TH-1:0]    temp_above,
  input  logic               clr_ovc_flag,
  input  logic               clr_hot_flag,
  output logic [GAIN_W-1:0]  eff_gain,
  output logic               pa_en,
  output logic               rsel_o,
  output logic               rsel_oe,
  output logic [ZONE_W-1:0]  temp_zone,
  output logic               limiting,
  output logic               ovc_flag,
  output logic               hot_flag
);

  localparam int N_FLAGS = 2;

  logic [N_FLAGS-1:0] flag_set;
  logic [N_FLAGS-1:0] flag_clr;
  logic [N_FLAGS-1:0] flag_q;

  pa_gain_backoff #(
    .GAIN_W (GAIN_W),
    .DWELL_W(DWELL_W)
  ) u_backoff (
    .clk      (clk),
    .rst      (rst),
    .host_gain(host_gain),
    .dwell_cfg(dwell_cfg),
    .tx_start (tx_start),
    .ovc_hi   (ovc_hi),
    .ovc_lo   (ovc_lo),
    .eff_gain (eff_gain),
    .limiting (limiting)
  );

  pa_thermal_guard #(
    .N_TH  (N_TH),
    .ZONE_W(ZONE_W)
  ) u_thermal (
    .clk       (clk),
    .rst       (rst),
    .temp_above(temp_above),
    .pa_en     (pa_en),
    .zone      (temp_zone)
  );

  assign flag_set = {temp_above[N_TH-1], ovc_hi};
  assign flag_clr = {clr_hot_flag, clr_ovc_flag};

  for (genvar i = 0; i < N_FLAGS; i++) begin : g_flag
    pa_sticky_flag u_flag (
      .clk   (clk),
      .rst   (rst),
      .set_i (flag_set[i]),
      .clr_i (flag_clr[i]),
      .flag_o(flag_q[i])
    );
  end

  assign ovc_flag = flag_q[0];
  assign hot_flag = flag_q[1];

  // resistor select: pulled low for FSK, released for PSK
  always_ff @(posedge clk) begin
    if (rst) rsel_oe <= 1'b0;
    else     rsel_oe <= mod_fsk;
  end
  assign rsel_o = 1'b0;

endmodule

// File: rtl/pa_guard_chk.sv
module pa_guard_chk #(
  parameter int GAIN_W  = 5,
  parameter int DWELL_W = 8,
  parameter int N_TH    = 4,
  parameter int ZONE_W  = $clog2(N_TH)
) (
  input logic               clk,
  input logic               rst,
  input logic [GAIN_W-1:0]  host_gain,
  input logic [DWELL_W-1:0] dwell_cfg,
  input logic               tx_start,
  input logic               ovc_hi,
  input logic               ovc_lo,
  input logic               mod_fsk,
  input logic [N_TH-1:0]    temp_above,
  input logic               clr_ovc_flag,
  input logic               clr_hot_flag,
  input logic [GAIN_W-1:0]  eff_gain,
  input logic               pa_en,
  input logic               rsel_o,
  input logic               rsel_oe,
  input logic [ZONE_W-1:0]  temp_zone,
  input logic               limiting,
  input logic               ovc_flag,
  input logic               hot_flag
);

  AST_GAIN_CAPPED: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> eff_gain <= $past(host_gain)); // R6

  AST_NO_RISE_WHILE_LIMITING: assert property (@(posedge clk) disable iff (rst)
    $past(limiting) && !$past(tx_start) |-> eff_gain <= $past(eff_gain)); // R5

  AST_START_RESTORES: assert property (@(posedge clk) disable iff (rst)
    tx_start |=> !limiting && eff_gain == $past(host_gain)); // R7

  AST_HOT_CUTS_PA: assert property (@(posedge clk) disable iff (rst)
    temp_above[N_TH-1] |=> !pa_en); // R9

  AST_OVC_FLAG_SET: assert property (@(posedge clk) disable iff (rst)
    ovc_hi |=> ovc_flag); // R11

  AST_HOT_FLAG_SET: assert property (@(posedge clk) disable iff (rst)
    temp_above[N_TH-1] |=> hot_flag); // R11

  AST_FSK_DRIVES: assert property (@(posedge clk) disable iff (rst)
    mod_fsk |=> rsel_oe && !rsel_o); // R8

  AST_ZONE_COOL: assert property (@(posedge clk) disable iff (rst)
    temp_above == '0 |=> temp_zone == '0); // R10

endmodule

bind pa_guard_ctrl pa_guard_chk #(
  .GAIN_W (GAIN_W),
  .DWELL_W(DWELL_W),
  .N_TH   (N_TH),
  .ZONE_W (ZONE_W)
) u_chk (.*);

// File: tb/pa_guard_ctrl_tb_top.sv
module pa_guard_ctrl_tb_top;

  localparam int GW = 5;
  localparam int DW = 8;
  localparam int NT = 4;
  localparam int ZW = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [GW-1:0] host_gain = '0;
  logic [DW-1:0] dwell_cfg = '0;
  logic          tx_start = 1'b0;
  logic          ovc_hi = 1'b0;
  logic          ovc_lo = 1'b0;
  logic          mod_fsk = 1'b0;
  logic [NT-1:0] temp_above = '0;
  logic          clr_ovc_flag = 1'b0;
  logic          clr_hot_flag = 1'b0;
  logic [GW-1:0] eff_gain;
  logic          pa_en, rsel_o, rsel_oe, limiting, ovc_flag, hot_flag;
  logic [ZW-1:0] temp_zone;

  always #2 clk = ~clk;

  pa_guard_ctrl #(.GAIN_W(GW), .DWELL_W(DW), .N_TH(NT)) dut_i (
    .clk(clk), .rst(rst), .host_gain(host_gain), .dwell_cfg(dwell_cfg),
    .tx_start(tx_start), .ovc_hi(ovc_hi), .ovc_lo(ovc_lo), .mod_fsk(mod_fsk),
    .temp_above(temp_above), .clr_ovc_flag(clr_ovc_flag), .clr_hot_flag(clr_hot_flag),
    .eff_gain(eff_gain), .pa_en(pa_en), .rsel_o(rsel_o), .rsel_oe(rsel_oe),
    .temp_zone(temp_zone), .limiting(limiting), .ovc_flag(ovc_flag), .hot_flag(hot_flag)
  );

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  // reference model state: 0 follow, 1 stepping, 2 holding
  int m_st, m_g, m_dw;
  bit m_sd, m_pa, m_cl, m_th, m_oe;
  int m_zone;

  function automatic int dec0(input int g);
    return (g > 0) ? g - 1 : 0;
  endfunction

  function automatic int capg(input int g, input int req);
    return (g > req) ? req : g;
  endfunction

  function automatic int zone_of(input logic [NT-1:0] t);
    if (t[2]) return 3;
    if (t[1]) return 2;
    if (t[0]) return 1;
    return 0;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_update();
    int h;
    bit sdn;
    h = int'(host_gain);
    if (rst) begin
      m_st = 0; m_g = 0; m_dw = 0; m_sd = 0; m_pa = 0;
      m_cl = 0; m_th = 0; m_oe = 0; m_zone = 0;
      return;
    end
    if (ovc_hi) m_cl = 1; else if (clr_ovc_flag) m_cl = 0;
    if (temp_above[3]) m_th = 1; else if (clr_hot_flag) m_th = 0;
    sdn  = temp_above[3] | (m_sd & temp_above[2]);
    m_sd = sdn;
    m_pa = !sdn;
    m_zone = zone_of(temp_above);
    m_oe = mod_fsk;
    if (tx_start) begin
      m_st = 0; m_g = h; m_dw = 0;
    end else if (m_st == 0) begin
      if (ovc_hi) begin m_st = 1; m_g = dec0(h); m_dw = int'(dwell_cfg); end
      else m_g = h;
    end else if (m_st == 1) begin
      if (!ovc_lo) begin m_st = 2; m_g = capg(m_g, h); end
      else if (m_dw != 0) begin m_dw--; m_g = capg(m_g, h); end
      else begin m_g = capg(dec0(m_g), h); m_dw = int'(dwell_cfg); end
    end else begin
      if (ovc_hi) begin m_st = 1; m_g = capg(dec0(m_g), h); m_dw = int'(dwell_cfg); end
      else m_g = capg(m_g, h);
    end
  endtask

  // one clock: inputs already stable, sample 1 ns after the edge
  task automatic cyc();
    @(posedge clk);
    model_update();
    #1;
    chk("R2/R3/R4/R5/R6/R7 eff_gain", int'(eff_gain), m_g);
    chk("R3/R5/R7 limiting", int'(limiting), (m_st != 0) ? 1 : 0);
    chk("R9 pa_en", int'(pa_en), int'(m_pa));
    chk("R10 temp_zone", int'(temp_zone), m_zone);
    chk("R8 rsel_oe", int'(rsel_oe), int'(m_oe));
    chk("R8 rsel_o", int'(rsel_o), 0);
    chk("R11 ovc_flag", int'(ovc_flag), int'(m_cl));
    chk("R11 hot_flag", int'(hot_flag), int'(m_th));
    @(negedge clk);
    tx_start = 1'b0;
    clr_ovc_flag = 1'b0;
    clr_hot_flag = 1'b0;
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int lvl;
    void'($urandom(32'd20240611));
    @(negedge clk);
    rst = 1'b1; host_gain = 5'd17; mod_fsk = 1'b1; temp_above = 4'b1111; ovc_hi = 1'b1;
    repeat (3) cyc();
    // R1 reset state
    chk("R1 eff_gain", int'(eff_gain), 0);
    chk("R1 pa_en", int'(pa_en), 0);
    chk("R1 flags", int'({ovc_flag, hot_flag, limiting, rsel_oe}), 0);
    chk("R1 temp_zone", int'(temp_zone), 0);
    rst = 1'b0; temp_above = '0; ovc_hi = 1'b0; mod_fsk = 1'b0;
    host_gain = 5'd20; dwell_cfg = 8'd2;
    cyc();
    chk("R2 follow", int'(eff_gain), 20);
    host_gain = 5'd22; cyc();
    chk("R2 follow change", int'(eff_gain), 22);
    host_gain = 5'd20;
    cyc();
    // R3 trip
    ovc_hi = 1'b1; ovc_lo = 1'b1; cyc();
    chk("R3 first step", int'(eff_gain), 19);
    chk("R3 limiting", int'(limiting), 1);
    // R4 dwell of 2 then step
    ovc_hi = 1'b0;
    cyc(); chk("R4 dwell", int'(eff_gain), 19);
    cyc(); chk("R4 dwell", int'(eff_gain), 19);
    cyc(); chk("R4 step", int'(eff_gain), 18);
    // R5 hold
    ovc_lo = 1'b0; host_gain = 5'd25;
    cyc(); chk("R5 hold", int'(eff_gain), 18);
    cyc(); chk("R5 hold", int'(eff_gain), 18);
    // R6 cap by a lower request
    host_gain = 5'd10;
    cyc(); chk("R6 cap", int'(eff_gain), 10);
    // R5 resume from held value
    ovc_hi = 1'b1; cyc();
    chk("R5 resume", int'(eff_gain), 9);
    // R6 floor at zero, dwell 0
    ovc_hi = 1'b0; ovc_lo = 1'b1; dwell_cfg = 8'd0;
    repeat (14) cyc();
    chk("R6 floor", int'(eff_gain), 0);
    // R7 start beats a trip in the same cycle
    ovc_hi = 1'b1; tx_start = 1'b1; cyc();
    chk("R7 restore", int'(eff_gain), 10);
    chk("R7 limiting", int'(limiting), 0);
    ovc_hi = 1'b0; ovc_lo = 1'b0;
    cyc();
    // R11 clear, then set beats clear
    clr_ovc_flag = 1'b1; cyc();
    chk("R11 cleared", int'(ovc_flag), 0);
    clr_ovc_flag = 1'b1; ovc_hi = 1'b1; cyc();
    chk("R11 set wins", int'(ovc_flag), 1);
    ovc_hi = 1'b0; tx_start = 1'b1; cyc();
    // R8
    mod_fsk = 1'b1; cyc();
    chk("R8 fsk oe", int'(rsel_oe), 1);
    mod_fsk = 1'b0; cyc();
    chk("R8 psk oe", int'(rsel_oe), 0);
    // R10 zones and R9 latch
    temp_above = 4'b0001; cyc(); chk("R10 zone2", int'(temp_zone), 1);
    temp_above = 4'b0011; cyc(); chk("R10 zone3", int'(temp_zone), 2);
    temp_above = 4'b0111; cyc(); chk("R10 zone4", int'(temp_zone), 3);
    chk("R9 on below trip", int'(pa_en), 1);
    temp_above = 4'b1111; cyc(); chk("R9 trip", int'(pa_en), 0);
    chk("R11 hot set", int'(hot_flag), 1);
    temp_above = 4'b0111; cyc(); chk("R9 still off", int'(pa_en), 0);
    clr_hot_flag = 1'b1; cyc(); chk("R11 hot clear", int'(hot_flag), 0);
    chk("R9 still off", int'(pa_en), 0);
    temp_above = 4'b0011; cyc(); chk("R9 release", int'(pa_en), 1);
    temp_above = 4'b0000;
    cyc();
    // random phase
    lvl = 0;
    for (int i = 0; i < 6000; i++) begin
      if ($urandom_range(0, 15) == 0) host_gain = GW'($urandom_range(0, 31));
      if ($urandom_range(0, 63) == 0) dwell_cfg = DW'($urandom_range(0, 4));
      tx_start = ($urandom_range(0, 40) == 0);
      ovc_hi = ($urandom_range(0, 9) == 0);
      ovc_lo = ovc_hi | ($urandom_range(0, 3) != 0);
      mod_fsk = ($urandom_range(0, 30) == 0) ? ~mod_fsk : mod_fsk;
      if ($urandom_range(0, 7) == 0) begin
        lvl = lvl + int'($urandom_range(0, 2)) - 1;
        if (lvl < 0) lvl = 0;
        if (lvl > 4) lvl = 4;
      end
      temp_above = NT'((1 << lvl) - 1);
      clr_ovc_flag = ($urandom_range(0, 11) == 0);
      clr_hot_flag = ($urandom_range(0, 11) == 0);
      if ($urandom_range(0, 1999) == 0) rst = 1'b1; else rst = 1'b0;
      cyc();
    end
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule